// File: doc/BRIEF.md
# Input Filter and Prescaler Cell

This cell conditions one digital input before it reaches timer logic. The input can come from a port line, from the module clock, or from the output of the cell before it in a chain. A port line first passes through a two-stage synchronizer. The conditioned signal is then either debounced or divided down, and the result appears on `sig_out`. Every change of `sig_out` is also marked by a one-cycle rising or falling strobe.

Two debounce styles are offered. The delayed style changes the output only after the new input level has been held for a programmed number of counting ticks. The immediate style follows the first edge at once and then ignores the input for that many ticks. In prescaler mode the cell emits one pulse, one module clock long, after every N selected input edges. The counting tick comes from a selectable enable: select 0 is every module clock, and the other selects are external enables, for example a prescaled clock or a phase-locked tick. Several cells can be chained by feeding one cell's `sig_out` to the next cell's `chain_in`.

Top module: `sig_cond_cell`

## Requirements
- R1: While reset is asserted and after it is released, `sig_out`, `rise_pls` and `fall_pls` are 0 and the mode is hold (11).
- R2: `cfg_src` selects the conditioned input: 00 and 11 select `pin_in` after two synchronizer flops, 01 selects an internal signal that toggles every module clock, and 10 selects `chain_in` directly.
- R3: `cfg_tick_sel` 0 makes every module clock a counting tick; a value k of 1 or more uses `ext_ticks[k-1]`. With no tick the debounce counters do not advance.
- R4: Mode 01 (delayed debounce) changes `sig_out` to the conditioned input on the tick at which that input has differed from `sig_out` for L consecutive ticks, where L is `cfg_limit` and 0 acts as 1. A mismatch shorter than that changes nothing.
- R5: Mode 10 (immediate debounce), when unlocked, copies a differing conditioned input to `sig_out` on the next clock and then locks. Input changes are ignored until L ticks have passed, with 0 acting as 1.
- R6: Mode 00 (prescaler) drives `sig_out` high for exactly one module clock after every max(N,1) selected edges of the conditioned input, where N is `cfg_limit`. `cfg_rise` = 1 counts rising edges and 0 counts falling edges.
- R7: `rise_pls` and `fall_pls` are each high for one cycle, never together, and high exactly in the cycles in which `sig_out` has just risen or fallen.
- R8: `cfg_we` loads all configuration fields. In that cycle `sig_out` holds its value, and if the mode or the limit changes, the internal counter and the lockout are cleared.
- R9: Mode 11 (hold) freezes `sig_out`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | 1 | Asynchronous port line |
| chain_in | input | 1 | Output of the preceding cell, synchronous |
| ext_ticks | input | N_TICK-1 | External counting-tick enables, selects 1 and up |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_mode | input | 2 | 00 prescale, 01 delayed, 10 immediate, 11 hold |
| cfg_src | input | 2 | Input source select |
| cfg_tick_sel | input | SEL_W | Counting tick select |
| cfg_rise | input | 1 | Prescaler edge: 1 rising, 0 falling |
| cfg_limit | input | CNT_W | Threshold or division count |
| sig_out | output | 1 | Filtered or prescaled signal |
| rise_pls | output | 1 | One-cycle strobe on a rise of `sig_out` |
| fall_pls | output | 1 | One-cycle strobe on a fall of `sig_out` |

## Verification
The assertions take three things for granted:
- `chain_in`, `ext_ticks` and all configuration fields are synchronous to `clk`.
- The configuration fields are valid whenever `cfg_we` is high.
- The port line holds each level for at least one full module clock, so it toggles no faster than half the clock rate.

The stimulus changes every input on the falling clock edge and holds each port-line level for one or more whole cycles. The prescaler mode is entered only while `sig_out` is low, so every strobe the bench sees is one it has scheduled.

// File: rtl/sc_pkg.sv
package sc_pkg;
   typedef enum logic [1:0] {
      M_PRESC = 2'b00,
      M_DELAY = 2'b01,
      M_IMMED = 2'b10,
      M_HOLD  = 2'b11
   } sc_mode_e;

   typedef enum logic [1:0] {
      SRC_PIN   = 2'b00,
      SRC_MCLK  = 2'b01,
      SRC_CHAIN = 2'b10,
      SRC_PIN2  = 2'b11
   } sc_src_e;
endpackage

// File: rtl/sc_in_sel.sv
module sc_in_sel #(
   parameter int SYNC_N = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin_in,
   input  logic       chain_in,
   input  logic [1:0] src_sel,
   output logic       s_cur,
   output logic       s_prev
);
   import sc_pkg::*;

   logic [SYNC_N-1:0] sync_q;
   logic              mclk_tgl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q   <= '0;
         mclk_tgl <= 1'b0;
         s_prev   <= 1'b0;
      end else begin
         sync_q   <= {sync_q[SYNC_N-2:0], pin_in};
         mclk_tgl <= ~mclk_tgl;
         s_prev   <= s_cur;
      end
   end

   always_comb begin
      unique case (sc_src_e'(src_sel))
         SRC_MCLK:  s_cur = mclk_tgl;
         SRC_CHAIN: s_cur = chain_in;
         default:   s_cur = sync_q[SYNC_N-1];
      endcase
   end
endmodule

// File: rtl/sc_tick_sel.sv
module sc_tick_sel #(
   parameter int N_TICK = 4,
   parameter int SEL_W  = 2
) (
   input  logic [N_TICK-2:0] ext_ticks,
   input  logic [SEL_W-1:0]  tick_sel,
   output logic              tick
);
   logic [N_TICK-1:0] all_ticks;

   assign all_ticks = {ext_ticks, 1'b1};

   if (N_TICK == (1 << SEL_W)) begin : g_full
      assign tick = all_ticks[tick_sel];
   end else begin : g_guard
      assign tick = (tick_sel < SEL_W'(N_TICK)) ? all_ticks[tick_sel] : 1'b0;
   end
endmodule

// File: rtl/sc_core.sv
module sc_core #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  sc_pkg::sc_mode_e mode_q,
   input  logic [CNT_W-1:0] lim_q,
   input  logic             edge_rise,
   input  logic             cfg_we,
   input  logic             cfg_chg,
   input  logic             s_cur,
   input  logic             s_prev,
   input  logic             tick,
   output logic             sig_out,
   output logic             rise_pls,
   output logic             fall_pls
);
   import sc_pkg::*;

   logic [CNT_W-1:0] cnt_q, cnt_n;
   logic             lock_q, lock_n, out_n;
   logic [CNT_W:0]   cnt_inc, lim_eff;
   logic             edge_hit, reach;

   assign cnt_inc  = {1'b0, cnt_q} + 1'b1;
   assign lim_eff  = (lim_q == '0) ? (CNT_W+1)'(1) : {1'b0, lim_q};
   assign reach    = (cnt_inc >= lim_eff);
   assign edge_hit = edge_rise ? (s_cur & ~s_prev) : (~s_cur & s_prev);

   always_comb begin
      out_n  = sig_out;
      cnt_n  = cnt_q;
      lock_n = lock_q;
      if (cfg_we) begin
         if (cfg_chg) begin
            cnt_n  = '0;
            lock_n = 1'b0;
         end
      end else begin
         unique case (mode_q)
            M_PRESC: begin
               out_n = 1'b0;
               if (edge_hit) begin
                  if (reach) begin
                     cnt_n = '0;
                     out_n = 1'b1;
                  end else begin
                     cnt_n = cnt_inc[CNT_W-1:0];
                  end
               end
            end
            M_DELAY: begin
               if (s_cur == sig_out) begin
                  cnt_n = '0;
               end else if (tick) begin
                  if (reach) begin
                     cnt_n = '0;
                     out_n = s_cur;
                  end else begin
                     cnt_n = cnt_inc[CNT_W-1:0];
                  end
               end
            end
            M_IMMED: begin
               if (lock_q) begin
                  if (tick) begin
                     if (reach) begin
                        cnt_n  = '0;
                        lock_n = 1'b0;
                     end else begin
                        cnt_n = cnt_inc[CNT_W-1:0];
                     end
                  end
               end else if (s_cur != sig_out) begin
                  out_n  = s_cur;
                  lock_n = 1'b1;
                  cnt_n  = '0;
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q    <= '0;
         lock_q   <= 1'b0;
         sig_out  <= 1'b0;
         rise_pls <= 1'b0;
         fall_pls <= 1'b0;
      end else begin
         cnt_q    <= cnt_n;
         lock_q   <= lock_n;
         sig_out  <= out_n;
         rise_pls <= out_n & ~sig_out;
         fall_pls <= ~out_n & sig_out;
      end
   end
endmodule

// File: rtl/sig_cond_cell.sv
module sig_cond_cell #(
   parameter int CNT_W  = 16,
   parameter int N_TICK = 4,
   parameter int SYNC_N = 2,
   localparam int SEL_W = (N_TICK > 1) ? $clog2(N_TICK) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pin_in,
   input  logic              chain_in,
   input  logic [N_TICK-2:0] ext_ticks,
   input  logic              cfg_we,
   input  logic [1:0]        cfg_mode,
   input  logic [1:0]        cfg_src,
   input  logic [SEL_W-1:0]  cfg_tick_sel,
   input  logic              cfg_rise,
   input  logic [CNT_W-1:0]  cfg_limit,
   output logic              sig_out,
   output logic              rise_pls,
   output logic              fall_pls
);
   import sc_pkg::*;

   if (CNT_W < 2)  begin : g_bad_cnt  $error("CNT_W must be at least 2");  end
   if (N_TICK < 2) begin : g_bad_tick $error("N_TICK must be at least 2"); end
   if (SYNC_N < 2) begin : g_bad_sync $error("SYNC_N must be at least 2"); end

   sc_mode_e         mode_q;
   logic [1:0]       src_q;
   logic [SEL_W-1:0] tsel_q;
   logic             rise_q;
   logic [CNT_W-1:0] lim_q;
   logic             cfg_chg, s_cur, s_prev, tick;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= M_HOLD;
         src_q  <= 2'b00;
         tsel_q <= '0;
         rise_q <= 1'b1;
         lim_q  <= '0;
      end else if (cfg_we) begin
         mode_q <= sc_mode_e'(cfg_mode);
         src_q  <= cfg_src;
         tsel_q <= cfg_tick_sel;
         rise_q <= cfg_rise;
         lim_q  <= cfg_limit;
      end
   end

   assign cfg_chg = (cfg_mode != mode_q) || (cfg_limit != lim_q);

   sc_in_sel #(.SYNC_N(SYNC_N)) u_in (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .chain_in(chain_in),
      .src_sel(src_q), .s_cur(s_cur), .s_prev(s_prev)
   );

   sc_tick_sel #(.N_TICK(N_TICK), .SEL_W(SEL_W)) u_tick (
      .ext_ticks(ext_ticks), .tick_sel(tsel_q), .tick(tick)
   );

   sc_core #(.CNT_W(CNT_W)) u_core (
      .clk(clk), .rst_n(rst_n), .mode_q(mode_q), .lim_q(lim_q),
      .edge_rise(rise_q), .cfg_we(cfg_we), .cfg_chg(cfg_chg),
      .s_cur(s_cur), .s_prev(s_prev), .tick(tick),
      .sig_out(sig_out), .rise_pls(rise_pls), .fall_pls(fall_pls)
   );
endmodule

// File: rtl/sig_cond_cell_chk.sv
module sig_cond_cell_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cfg_we,
   input logic [1:0] mode_q,
   input logic       tick,
   input logic       sig_out,
   input logic       rise_pls,
   input logic       fall_pls
);
   // R7
   strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_pls && fall_pls));

   // R7
   rise_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rise_pls |-> (sig_out && !$past(sig_out)));

   // R7
   fall_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fall_pls |-> (!sig_out && $past(sig_out)));

   // R7
   change_strobed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sig_out != $past(sig_out)) |-> (rise_pls || fall_pls));

   // R8
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_we |=> $stable(sig_out));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b11) |=> $stable(sig_out));

   // R3
   tick_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b01 && !tick) |=> $stable(sig_out));

   // R6
   presc_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q == 2'b00 && sig_out && !cfg_we) |=> !sig_out);
endmodule

bind sig_cond_cell sig_cond_cell_chk u_chk (
   .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .mode_q(mode_q),
   .tick(tick), .sig_out(sig_out), .rise_pls(rise_pls), .fall_pls(fall_pls)
);

// File: tb/sim_sig_cond_cell.sv
`timescale 1ns/1ps
module sim_sig_cond_cell;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pin_in = 1'b0;
   logic        chain_in = 1'b0;
   logic [2:0]  ext_ticks = '0;
   logic        cfg_we = 1'b0;
   logic [1:0]  cfg_mode = 2'b11;
   logic [1:0]  cfg_src = 2'b00;
   logic [1:0]  cfg_tick_sel = 2'b00;
   logic        cfg_rise = 1'b1;
   logic [15:0] cfg_limit = '0;
   logic        sig_out, rise_pls, fall_pls;

   typedef struct {
      bit    rise;
      int    cyc;
      string req;
   } exp_t;

   exp_t exp_q[$];
   int   cyc = 0;
   int   n_chk = 0;
   int   n_fail = 0;
   bit   mon_en = 1'b1;
   int   rise_cnt = 0;
   int   fall_cnt = 0;
   bit   done = 1'b0;

   sig_cond_cell u0 (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .chain_in(chain_in),
      .ext_ticks(ext_ticks), .cfg_we(cfg_we), .cfg_mode(cfg_mode),
      .cfg_src(cfg_src), .cfg_tick_sel(cfg_tick_sel), .cfg_rise(cfg_rise),
      .cfg_limit(cfg_limit), .sig_out(sig_out), .rise_pls(rise_pls),
      .fall_pls(fall_pls)
   );

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(bit ok, string req, string what, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic expect_at(bit rise, int c, string req);
      exp_t e;
      e.rise = rise;
      e.cyc  = c;
      e.req  = req;
      exp_q.push_back(e);
   endtask

   task automatic drain(string req);
      chk(exp_q.size() == 0, req, "pending strobes", exp_q.size(), 0);
      exp_q.delete();
   endtask

   task automatic cfg(int m, int lim, bit r, int src, int tsel);
      cfg_we       = 1'b1;
      cfg_mode     = 2'(m);
      cfg_limit    = 16'(lim);
      cfg_rise     = r;
      cfg_src      = 2'(src);
      cfg_tick_sel = 2'(tsel);
      step(1);
      cfg_we = 1'b0;
   endtask

   task automatic chain_pulse();
      chain_in = 1'b1;
      step(1);
      chain_in = 1'b0;
      step(1);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && (rise_pls || fall_pls)) begin
         if (!mon_en) begin
            if (rise_pls) rise_cnt++;
            if (fall_pls) fall_cnt++;
         end else if (exp_q.size() == 0) begin
            chk(1'b0, "R7", "unexpected strobe at cycle", cyc, -1);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            chk(rise_pls == e.rise, e.req, "strobe kind (1=rise)", int'(rise_pls), int'(e.rise));
            chk(cyc == e.cyc, e.req, "strobe cycle", cyc, e.cyc);
         end
      end
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         chk(1'b0, "watchdog", "cycles", cyc, 200000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      int c;
      step(3);
      // R1 reset state
      chk(sig_out == 1'b0 && rise_pls == 1'b0 && fall_pls == 1'b0, "R1", "outputs in reset",
          {sig_out, rise_pls, fall_pls}, 0);
      rst_n = 1'b1;
      step(2);
      chk(sig_out == 1'b0, "R1", "sig_out after reset", sig_out, 0);

      // R9 hold mode after reset ignores input
      pin_in = 1'b1;
      step(10);
      chk(sig_out == 1'b0, "R9", "held output", sig_out, 0);
      pin_in = 1'b0;
      step(5);

      // R4 delayed debounce, L=4, pin source (R2 latency)
      cfg(1, 4, 1'b1, 0, 0);
      step(2);
      c = cyc; pin_in = 1'b1; expect_at(1'b1, c + 6, "R4");
      step(15); drain("R4");
      chk(sig_out == 1'b1, "R2", "pin level reached output", sig_out, 1);
      pin_in = 1'b0; step(2); pin_in = 1'b1;   // glitch shorter than L
      step(15); drain("R4");
      chk(sig_out == 1'b1, "R4", "short glitch filtered", sig_out, 1);
      c = cyc; pin_in = 1'b0; expect_at(1'b0, c + 6, "R4");
      step(15); drain("R4");

      // R4 limit 0 acts as 1
      cfg(1, 0, 1'b1, 0, 0);
      step(2);
      c = cyc; pin_in = 1'b1; expect_at(1'b1, c + 3, "R4");
      step(10);
      c = cyc; pin_in = 1'b0; expect_at(1'b0, c + 3, "R4");
      step(10); drain("R4");

      // R3 external tick select
      cfg(1, 3, 1'b1, 0, 1);
      pin_in = 1'b1;
      step(20);
      chk(sig_out == 1'b0, "R3", "no tick, no change", sig_out, 0);
      c = cyc; ext_ticks = 3'b001; expect_at(1'b1, c + 3, "R3");
      step(10); drain("R3");
      ext_ticks = 3'b000;
      pin_in = 1'b0;
      step(20);
      chk(sig_out == 1'b1, "R3", "no tick, held high", sig_out, 1);
      cfg(1, 3, 1'b1, 0, 2);
      c = cyc; ext_ticks = 3'b010; expect_at(1'b0, c + 3, "R3");
      step(10); drain("R3");
      ext_ticks = 3'b000;

      // R8 limit change mid-count clears the counter
      cfg(1, 4, 1'b1, 0, 0);
      step(2);
      c = cyc; pin_in = 1'b1; expect_at(1'b1, c + 11, "R8");
      step(4);
      cfg(1, 6, 1'b1, 0, 0);
      step(15); drain("R8");
      c = cyc; pin_in = 1'b0; expect_at(1'b0, c + 8, "R8");
      step(15); drain("R8");

      // R5 immediate debounce, L=5: lockout then re-follow
      cfg(2, 5, 1'b1, 0, 0);
      step(2);
      c = cyc; pin_in = 1'b1;
      expect_at(1'b1, c + 3, "R5");
      expect_at(1'b0, c + 9, "R5");
      step(1); pin_in = 1'b0;
      step(20); drain("R5");
      c = cyc; pin_in = 1'b1; expect_at(1'b1, c + 3, "R5");
      step(1); pin_in = 1'b0; step(1); pin_in = 1'b1;   // bounce inside lockout
      step(20); drain("R5");
      chk(sig_out == 1'b1, "R5", "bounce ignored", sig_out, 1);
      c = cyc; pin_in = 1'b0; expect_at(1'b0, c + 3, "R5");
      step(15); drain("R5");

      // R6 prescaler on chain input, rising edges, N=3
      cfg(0, 3, 1'b1, 2, 0);
      step(2);
      for (int i = 0; i < 6; i++) begin
         if (i % 3 == 2) begin
            expect_at(1'b1, cyc + 1, "R6");
            expect_at(1'b0, cyc + 2, "R6");
         end
         chain_pulse();
      end
      step(6); drain("R6");

      // R6 prescaler, falling edges, N=2
      cfg(0, 2, 1'b0, 2, 0);
      step(2);
      for (int i = 0; i < 4; i++) begin
         if (i % 2 == 1) begin
            expect_at(1'b1, cyc + 2, "R6");
            expect_at(1'b0, cyc + 3, "R6");
         end
         chain_pulse();
      end
      step(6); drain("R6");

      // R2 module-clock source through prescaler N=4: one pulse per 8 cycles
      mon_en = 1'b0;
      cfg(0, 4, 1'b1, 1, 0);
      step(10);
      rise_cnt = 0; fall_cnt = 0;
      step(80);
      chk(rise_cnt == 10, "R2", "rises in 80 cycles", rise_cnt, 10);
      chk(fall_cnt == 10, "R2", "falls in 80 cycles", fall_cnt, 10);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule